// File: doc/BRIEF.md
# Playback Ring Buffer Consumer

This block is the transmit half of an audio DMA engine. Software places sample words in a circular region of memory and moves a producer index forward. The block reads the words back in bursts of fixed size and moves its own consumer index forward. It sends the words downstream on a valid/ready stream. Both indices are byte offsets into a power-of-two buffer, and they wrap at its end. When consumer and producer are equal, the buffer is empty.

A burst starts only when three conditions hold. At least one whole burst of bytes must lie between the two indices. No earlier burst may still be outstanding. The holding buffer toward the stream must have room for the whole burst. When the last word of a burst arrives, the consumer index moves forward by the burst size and a one-cycle pulse goes to the interrupt logic. A read-only register tells software the burst size. A soft-reset command clears the transmit path.

Top module: `pbk_consumer`

## Requirements
- R1: After reset, `out_valid`, `mem_req` and `burst_done` are low. The consumer index (offset 0x10) reads 0. Offset 0x58 reads the burst size in bytes in bits [23:8], with every other bit zero. With the defaults this value is 0x1000.
- R2: Register offsets are: enable bit 0 at 0x00, base address at 0x04, buffer size in bytes at 0x08, producer index at 0x0c, consumer index at 0x10. The first four read back what was written. A write to 0x10 is ignored. Read data appears on `reg_rdata` in the cycle after `reg_rd`.
- R3: No memory read is issued while the consumer index equals the producer index.
- R4: No burst starts while the enable bit is 0, or while fewer than one burst of bytes is available, where available = (producer − consumer) mod size.
- R5: A burst reads BURST_WORDS consecutive words at base + ((consumer + 4·i) mod size). The words go out on the stream in order. After the last word returns, the consumer index becomes (consumer + burst bytes) mod size.
- R6: Indices wrap at the buffer size. A burst that ends exactly at the end of the buffer sets the consumer index to 0. A producer index below the consumer index still counts as data available.
- R7: `burst_done` is high for exactly one cycle per completed burst. It is raised on the same clock edge that advances the consumer index.
- R8: A burst starts only when the holding buffer has room for a whole burst. While `out_ready` is low, `out_valid` and `out_data` stay stable, and no new burst starts once the buffer lacks room.
- R9: A write to 0x2c with bit 1 set does all of the following: clears the enable bit, the producer index, the consumer index and the holding buffer; stops the current burst; and drops any read data still in flight. A write to 0x2c with bit 1 clear has no effect.
- R10: A software write to the producer index in the same cycle that a burst completes takes effect. The consumer index still advances in that cycle, and the next burst uses the new producer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| mem_req | output | 1 | Word read request to memory |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid from memory |
| mem_rdata | input | DATA_W | Read data from memory |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | DATA_W | Stream word |
| burst_done | output | 1 | One-cycle pulse per completed burst |

## Verification
Two functions can fall in the same cycle: software writing the producer index, and the hardware completing a burst and advancing the consumer index. The bench counts the read responses coming back from its memory model. It issues the producer write in exactly the cycle the fourth response of a burst is presented. It then requires `burst_done` to be seen at that edge, both indices to hold their expected new values, and a second burst to follow with the correct words. A soft reset landing in the middle of a burst is provoked the same way, and it is judged by the absence of any stale word on the stream.

// File: rtl/pbk_pkg.sv
`timescale 1ns/1ps
package pbk_pkg;
  localparam logic [7:0] OFS_ENABLE = 8'h00;
  localparam logic [7:0] OFS_BASE   = 8'h04;
  localparam logic [7:0] OFS_SIZE   = 8'h08;
  localparam logic [7:0] OFS_PROD   = 8'h0c;
  localparam logic [7:0] OFS_CONS   = 8'h10;
  localparam logic [7:0] OFS_SRST   = 8'h2c;
  localparam logic [7:0] OFS_BURST  = 8'h58;
  localparam int unsigned SRST_TX_BIT = 1;

  typedef enum logic [1:0] {FS_IDLE, FS_ISSUE, FS_WAIT} fetch_state_e;
endpackage

// File: rtl/pbk_regs.sv
`timescale 1ns/1ps
module pbk_regs
  import pbk_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned IDX_W       = 21,
  parameter int unsigned BURST_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [IDX_W-1:0]  cons_idx,
  output logic              enable,
  output logic [ADDR_W-1:0] base_addr,
  output logic [IDX_W-1:0]  buf_mask,
  output logic [IDX_W-1:0]  prod_idx,
  output logic              soft_rst
);
  localparam int unsigned SIZE_W = IDX_W + 1;

  logic [SIZE_W-1:0] size_q;

  assign soft_rst = reg_wr && (reg_addr == OFS_SRST) && reg_wdata[SRST_TX_BIT];
  assign buf_mask = size_q[IDX_W-1:0] - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable    <= 1'b0;
      base_addr <= '0;
      size_q    <= '0;
      prod_idx  <= '0;
    end else if (soft_rst) begin
      enable   <= 1'b0;
      prod_idx <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_ENABLE: enable    <= reg_wdata[0];
        OFS_BASE:   base_addr <= reg_wdata[ADDR_W-1:0];
        OFS_SIZE:   size_q    <= reg_wdata[SIZE_W-1:0];
        OFS_PROD:   prod_idx  <= reg_wdata[IDX_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_ENABLE: reg_rdata <= {31'b0, enable};
        OFS_BASE:   reg_rdata <= 32'(base_addr);
        OFS_SIZE:   reg_rdata <= 32'(size_q);
        OFS_PROD:   reg_rdata <= 32'(prod_idx);
        OFS_CONS:   reg_rdata <= 32'(cons_idx);
        OFS_BURST:  reg_rdata <= (32'(BURST_BYTES) & 32'h0000_FFFF) << 8;
        default:    reg_rdata <= '0;
      endcase
    end
  end

  AST_SRST_CLEARS_SW: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!enable && prod_idx == '0)); // R9
endmodule

// File: rtl/pbk_hold.sv
`timescale 1ns/1ps
module pbk_hold #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic              pop;

  assign out_valid = (count != '0);
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CNT_W'(DEPTH) || pop)); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data))); // R8
endmodule

// File: rtl/pbk_fetch.sv
`timescale 1ns/1ps
module pbk_fetch
  import pbk_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned IDX_W       = 21,
  parameter int unsigned BURST_WORDS = 4,
  parameter int unsigned WORD_BYTES  = 4,
  parameter int unsigned SPACE_W     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic [IDX_W-1:0]   buf_mask,
  input  logic [IDX_W-1:0]   prod_idx,
  input  logic               soft_rst,
  input  logic [SPACE_W-1:0] hold_space,
  input  logic               mem_rvalid,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               push,
  output logic [IDX_W-1:0]   cons_idx,
  output logic               burst_done
);
  localparam int unsigned CNT_W       = $clog2(BURST_WORDS + 1);
  localparam int unsigned BURST_BYTES = BURST_WORDS * WORD_BYTES;
  localparam int unsigned WSH         = $clog2(WORD_BYTES);

  fetch_state_e      state;
  logic [CNT_W-1:0]  off, rcnt, pend, ignore_cnt, pend_n, issue_off;
  logic [IDX_W-1:0]  avail;
  logic [ADDR_W-1:0] issue_addr;
  logic              start, last_rsp;

  always_comb begin
    avail      = (prod_idx - cons_idx) & buf_mask;
    issue_off  = (state == FS_IDLE) ? '0 : off;
    issue_addr = base_addr + ADDR_W'((cons_idx + (IDX_W'(issue_off) << WSH)) & buf_mask);
    start      = (state == FS_IDLE) && enable && !soft_rst &&
                 (pend == '0) && (ignore_cnt == '0) &&
                 (avail >= IDX_W'(BURST_BYTES)) &&
                 (hold_space >= SPACE_W'(BURST_WORDS));
    push       = mem_rvalid && (ignore_cnt == '0) && !soft_rst;
    last_rsp   = push && (rcnt == CNT_W'(BURST_WORDS - 1));
    pend_n     = pend + CNT_W'(mem_req) - CNT_W'(mem_rvalid);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= FS_IDLE;
      off        <= '0;
      rcnt       <= '0;
      pend       <= '0;
      ignore_cnt <= '0;
      cons_idx   <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      burst_done <= 1'b0;
    end else begin
      pend       <= pend_n;
      burst_done <= 1'b0;
      if (soft_rst) begin
        state      <= FS_IDLE;
        off        <= '0;
        rcnt       <= '0;
        cons_idx   <= '0;
        mem_req    <= 1'b0;
        ignore_cnt <= pend_n;
      end else begin
        if (mem_rvalid && ignore_cnt != '0) ignore_cnt <= ignore_cnt - 1'b1;
        case (state)
          FS_IDLE: if (start) begin
            mem_req  <= 1'b1;
            mem_addr <= issue_addr;
            off      <= CNT_W'(1);
            state    <= FS_ISSUE;
          end
          FS_ISSUE: if (off == CNT_W'(BURST_WORDS)) begin
            mem_req <= 1'b0;
            state   <= FS_WAIT;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= issue_addr;
            off      <= off + 1'b1;
          end
          default: ;
        endcase
        if (push) begin
          if (last_rsp) begin
            rcnt       <= '0;
            cons_idx   <= (cons_idx + IDX_W'(BURST_BYTES)) & buf_mask;
            burst_done <= 1'b1;
            state      <= FS_IDLE;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
      end
    end
  end

  AST_NO_EMPTY_FETCH: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(avail >= IDX_W'(BURST_BYTES))); // R3
  AST_CONS_STEP: assert property (@(posedge clk) disable iff (rst)
    (cons_idx != $past(cons_idx)) |->
      (cons_idx == '0 || cons_idx == (($past(cons_idx) + IDX_W'(BURST_BYTES)) & $past(buf_mask)))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    burst_done |=> !burst_done); // R7
  AST_SRST_ABORT: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (cons_idx == '0 && !mem_req)); // R9
endmodule

// File: rtl/pbk_consumer.sv
`timescale 1ns/1ps
module pbk_consumer #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned IDX_W       = 21,
  parameter int unsigned BURST_WORDS = 4,
  parameter int unsigned HOLD_WORDS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              burst_done
);
  localparam int unsigned WORD_BYTES  = DATA_W / 8;
  localparam int unsigned BURST_BYTES = BURST_WORDS * WORD_BYTES;
  localparam int unsigned SPACE_W     = $clog2(HOLD_WORDS + 1);

  logic               enable, soft_rst, push;
  logic [ADDR_W-1:0]  base_addr;
  logic [IDX_W-1:0]   buf_mask, prod_idx, cons_idx;
  logic [SPACE_W-1:0] hold_count, hold_space;

  assign hold_space = SPACE_W'(HOLD_WORDS) - hold_count;

  pbk_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BURST_BYTES(BURST_BYTES)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cons_idx(cons_idx),
    .enable(enable), .base_addr(base_addr), .buf_mask(buf_mask),
    .prod_idx(prod_idx), .soft_rst(soft_rst)
  );

  pbk_fetch #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BURST_WORDS(BURST_WORDS),
              .WORD_BYTES(WORD_BYTES), .SPACE_W(SPACE_W)) u_fetch (
    .clk(clk), .rst(rst), .enable(enable), .base_addr(base_addr),
    .buf_mask(buf_mask), .prod_idx(prod_idx), .soft_rst(soft_rst),
    .hold_space(hold_space), .mem_rvalid(mem_rvalid), .mem_req(mem_req),
    .mem_addr(mem_addr), .push(push), .cons_idx(cons_idx), .burst_done(burst_done)
  );

  pbk_hold #(.DATA_W(DATA_W), .DEPTH(HOLD_WORDS)) u_hold (
    .clk(clk), .rst(rst), .flush(soft_rst), .push(push), .push_data(mem_rdata),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .count(hold_count)
  );
endmodule

// File: tb/sim_pbk_consumer.sv
`timescale 1ns/1ps
module sim_pbk_consumer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        burst_done;

  int checks = 0, fails = 0;
  int irq_cnt, req_cnt, rv_cnt;
  logic [31:0] got[$];
  logic [31:0] memw [64];

  always #2 clk = ~clk;

  pbk_consumer u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .burst_done(burst_done)
  );

  function automatic logic [31:0] pat(int i);
    return 32'hC0DE_0000 | 32'(i & 63);
  endfunction

  initial for (int i = 0; i < 64; i++) memw[i] = pat(i);

  always @(posedge clk) begin
    if (rst) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      irq_cnt <= 0; req_cnt <= 0; rv_cnt <= 0;
    end else begin
      mem_rvalid <= mem_req;
      mem_rdata  <= memw[mem_addr[7:2]];
      if (burst_done) irq_cnt <= irq_cnt + 1;
      if (mem_req) req_cnt <= req_cnt + 1;
      if (mem_rvalid) rv_cnt <= rv_cnt + 1;
      if (out_valid && out_ready) got.push_back(out_data);
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hard_reset();
    @(negedge clk); rst = 1'b1; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    got.delete();
  endtask

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic cfg(logic [31:0] base, logic [31:0] size, bit en);
    reg_write(8'h04, base);
    reg_write(8'h08, size);
    if (en) reg_write(8'h00, 32'h1);
  endtask

  task automatic wait_irq(int n);
    for (int i = 0; i < 2000 && irq_cnt < n; i++) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic check_words(string tag, int first, int n);
    check(got.size() == n, tag, 32'(got.size()), 32'(n));
    for (int i = 0; i < n && i < got.size(); i++)
      check(got[i] == pat(first + i), tag, got[i], pat(first + i));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    hard_reset();
    check(!out_valid && !mem_req && !burst_done, "R1 outputs idle", {29'b0, out_valid, mem_req, burst_done}, 0);
    reg_read(8'h10, d); check(d == 0, "R1 consumer", d, 0);
    reg_read(8'h58, d); check(d == 32'h1000, "R1 burst size const", d, 32'h1000);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    hard_reset();
    cfg(32'h40, 64, 1'b0);
    reg_read(8'h04, d); check(d == 32'h40, "R2 base readback", d, 32'h40);
    reg_read(8'h08, d); check(d == 64, "R2 size readback", d, 64);
    reg_write(8'h0c, 32'h8);
    reg_read(8'h0c, d); check(d == 8, "R2 producer readback", d, 8);
    reg_write(8'h10, 32'h8);
    reg_read(8'h10, d); check(d == 0, "R2 consumer write ignored", d, 0);
  endtask

  task automatic t_empty_partial();
    hard_reset();
    cfg(32'h40, 64, 1'b1);
    repeat (40) @(negedge clk);
    check(req_cnt == 0, "R3 no fetch when empty", 32'(req_cnt), 0);
    reg_write(8'h0c, 32'd12);
    repeat (40) @(negedge clk);
    check(req_cnt == 0, "R4 partial burst not fetched", 32'(req_cnt), 0);
    hard_reset();
    cfg(32'h40, 64, 1'b0);
    reg_write(8'h0c, 32'd16);
    repeat (40) @(negedge clk);
    check(req_cnt == 0, "R4 disabled no fetch", 32'(req_cnt), 0);
    reg_write(8'h00, 32'h1);
    wait_irq(1);
    check_words("R4 fetch after enable", 16, 4);
  endtask

  task automatic t_single();
    logic [31:0] d;
    hard_reset();
    cfg(32'h40, 64, 1'b1);
    reg_write(8'h0c, 32'd16);
    wait_irq(1);
    check_words("R5 burst data", 16, 4);
    check(irq_cnt == 1, "R7 one pulse per burst", 32'(irq_cnt), 1);
    check(req_cnt == 4, "R5 word reads per burst", 32'(req_cnt), 4);
    reg_read(8'h10, d); check(d == 16, "R5 consumer advance", d, 16);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    hard_reset();
    cfg(32'h40, 64, 1'b1);
    reg_write(8'h0c, 32'd48);
    wait_irq(3);
    reg_read(8'h10, d); check(d == 48, "R6 consumer before wrap", d, 48);
    reg_write(8'h0c, 32'd0);
    wait_irq(4);
    reg_read(8'h10, d); check(d == 0, "R6 consumer wraps to 0", d, 0);
    check(irq_cnt == 4, "R6 wrap burst count", 32'(irq_cnt), 4);
    check_words("R6 ring order", 16, 16);
  endtask

  task automatic t_backpressure();
    logic [31:0] d, first;
    hard_reset();
    out_ready = 1'b0;
    cfg(32'h0, 256, 1'b1);
    reg_write(8'h0c, 32'd128);
    repeat (60) @(negedge clk);
    check(irq_cnt == 2, "R8 bursts limited by holding room", 32'(irq_cnt), 2);
    check(req_cnt == 8, "R8 reads limited", 32'(req_cnt), 8);
    check(out_valid && out_data == pat(0), "R8 head word held", out_data, pat(0));
    first = out_data;
    repeat (5) @(negedge clk);
    check(out_data == first, "R8 data stable under backpressure", out_data, first);
    reg_read(8'h10, d); check(d == 32, "R8 consumer at two bursts", d, 32);
    out_ready = 1'b1;
    wait_irq(8);
    check_words("R8 order after release", 0, 32);
    reg_read(8'h10, d); check(d == 128, "R8 consumer final", d, 128);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    hard_reset();
    cfg(32'h0, 64, 1'b1);
    reg_write(8'h0c, 32'd16);
    for (int i = 0; i < 200 && !mem_req; i++) @(negedge clk);
    reg_write(8'h2c, 32'h2);
    repeat (20) @(negedge clk);
    check(irq_cnt == 0, "R9 burst aborted", 32'(irq_cnt), 0);
    check(got.size() == 0, "R9 stale words dropped", 32'(got.size()), 0);
    reg_read(8'h10, d); check(d == 0, "R9 consumer cleared", d, 0);
    reg_read(8'h0c, d); check(d == 0, "R9 producer cleared", d, 0);
    reg_read(8'h00, d); check(d == 0, "R9 enable cleared", d, 0);
    reg_write(8'h00, 32'h1);
    reg_write(8'h0c, 32'd16);
    wait_irq(1);
    check_words("R9 clean burst after soft reset", 0, 4);
    reg_write(8'h2c, 32'h1);
    reg_read(8'h10, d); check(d == 16, "R9 bit1 clear no effect on consumer", d, 16);
    reg_read(8'h00, d); check(d == 1, "R9 bit1 clear no effect on enable", d, 1);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    hard_reset();
    cfg(32'h0, 64, 1'b1);
    reg_write(8'h0c, 32'd16);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (mem_rvalid && rv_cnt == 3) break;
    end
    reg_wr = 1'b1; reg_addr = 8'h0c; reg_wdata = 32'd32;
    @(negedge clk); reg_wr = 1'b0;
    check(burst_done, "R10 completion on write edge", {31'b0, burst_done}, 1);
    wait_irq(2);
    reg_read(8'h10, d); check(d == 32, "R10 consumer after both bursts", d, 32);
    reg_read(8'h0c, d); check(d == 32, "R10 producer write kept", d, 32);
    check_words("R10 data across collision", 0, 8);
  endtask

  initial begin
    #600000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_empty_partial();
    t_single();
    t_wrap();
    t_backpressure();
    t_soft_reset();
    t_collision();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule